// File: doc/BRIEF.md
# Single-Bus Hardwired Control Sequencer

This block steps a small processor through instruction fetch and execution when every register shares one internal bus. The program counter, memory address and data registers, the instruction register, the Y and Z temporaries and the general registers all sit on that bus. A step counter produces one timing line per step. Fixed AND-OR equations combine those timing lines with the decoded opcode to drive every gating signal. These signals are the bus out-enables, the register load enables, the memory read strobe, the ALU operation, the choice between Y and the PC increment on the ALU's A input, and the wait-for-memory request. No microcode store is involved.

A datapath model sits under the sequencer so that the pair can run whole instructions against a memory that answers with a completion strobe. Three instructions are decoded: add and subtract of a memory operand addressed through a pointer register, and a relative branch. Any other word ends right after fetch and raises an illegal-instruction flag. The shared bus, the current step and the end-of-instruction strobe are brought out so that results can be observed.

Top module: `sbc_hw_seq`

## Requirements
- R1: While rst_n is low, step_mon reads 1, instr_end and illegal_op are 0 and mem_read is 1. The first fetch after reset reads address RESET_PC (default 0x0100).
- R2: Every instruction starts with a three-step fetch. Step 1 puts the PC on the bus, loads it into the address register and pulses mem_read. Step 2 stores PC+PC_STEP (default 4) into both PC and Y and waits for memory. Step 3 copies the returned word into the instruction register. Successive fetches read consecutive addresses unless a branch intervenes.
- R3: In a step that waits for memory, step_mon holds its value until mem_mfc is 1. The step then advances at the next clock edge. Each cycle of memory latency therefore adds exactly one cycle to the instruction.
- R4: Opcode 0x1 (bits 15:12, with bits 11:8 zero) adds indirectly. The pointer register is bits 7:4 and the destination register is bits 3:0. The destination gets its old value plus the memory word at the pointer's address. The sum is on bus_mon in step 7, with instr_end high. Without stalls the instruction takes 7 cycles.
- R5: Opcode 0x2 subtracts indirectly with the same fields. The destination gets its old value minus the memory word. The result is on bus_mon in step 7 with instr_end high.
- R6: Opcode 0x3 branches. PC becomes the incremented PC plus the sign-extended bits 7:0. The target is on bus_mon in step 5 with instr_end high, and the next fetch reads the target. The stall-free length is 5 cycles.
- R7: A word with any other opcode, or with bits 11:8 nonzero, raises instr_end and illegal_op together in step 4. The bus then reads 0, no register changes, and the stall-free length is 4 cycles.
- R8: In any step, at most one source drives the shared bus.
- R9: Z loads only in step 1, in step 6 of add and subtract, and in step 4 of a branch. PC loads only in step 2 and in step 5 of a branch.
- R10: The cycle after instr_end, step_mon is 1.
- R11: After reset, general register i holds the value i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_mfc | input | 1 | Memory function complete; also loads the data register |
| mem_rdata | input | DATA_W | Word returned by memory |
| mem_read | output | 1 | Read request for the address on mem_addr |
| mem_addr | output | DATA_W | Memory address register contents |
| bus_mon | output | DATA_W | Value on the shared internal bus |
| step_mon | output | STEP_W | Current step number, 1 to 7 |
| instr_end | output | 1 | Last step of the current instruction |
| illegal_op | output | 1 | Undecoded instruction word, valid with instr_end |

## Verification
Each result is due when instr_end pulses. Add and subtract end 7 cycles after the fetch step begins, a branch after 5 and an illegal word after 4. Every wait step adds one cycle per cycle of memory latency. The scoreboard entry for each instruction carries its result, its illegal flag and its cycle count, derived from the address-dependent latency the memory responder applies. The monitor samples mid-cycle, counts cycles from one instr_end to the next, and compares all three values at the end pulse. Addresses are checked one cycle after the read strobe, once the address register has loaded.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   localparam int NSTEP = 7;

   localparam logic [3:0] OPC_ADDI = 4'h1;
   localparam logic [3:0] OPC_SUBI = 4'h2;
   localparam logic [3:0] OPC_BRAN = 4'h3;

   typedef enum logic [1:0] {
      ALU_ADD   = 2'd0,
      ALU_SUB   = 2'd1,
      ALU_XOR   = 2'd2,
      ALU_PASSB = 2'd3
   } alu_op_e;

   // one bit per gating line of the single-bus datapath
   typedef struct packed {
      logic    pc_out;
      logic    z_out;
      logic    mdr_out;
      logic    rs_out;
      logic    rd_out;
      logic    off_out;
      logic    pc_in;
      logic    mar_in;
      logic    y_in;
      logic    z_in;
      logic    ir_in;
      logic    rd_in;
      logic    rd_req;
      logic    wmfc;
      logic    sel4;
      logic    fin;
      logic    bad;
      alu_op_e alu;
   } ctrl_t;
endpackage

// File: rtl/sbc_step_ctr.sv
module sbc_step_ctr #(
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wmfc,
   input  logic              mfc,
   input  logic              fin,
   output logic [STEP_W-1:0] step
);
   localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);
   localparam logic [STEP_W-1:0] LAST  = STEP_W'(sbc_pkg::NSTEP);

   if (sbc_pkg::NSTEP >= (1 << STEP_W)) begin : g_bad_width
      $error("STEP_W too narrow for the step count");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             step <= FIRST;
      else if (fin)           step <= FIRST;
      else if (wmfc && !mfc)  step <= step;
      else                    step <= step + FIRST;
   end

   p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wmfc && !mfc) |=> $stable(step));

   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (step == FIRST));

   p_step_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step >= FIRST) && (step <= LAST));
endmodule

// File: rtl/sbc_decode.sv
module sbc_decode
   import sbc_pkg::*;
#(
   parameter int STEP_W = 3,
   parameter int HI_W   = 8
) (
   input  logic [STEP_W-1:0] step,
   input  logic [HI_W-1:0]   ir_hi,
   output ctrl_t             c
);
   localparam int RSV_W = HI_W - 4;

   if (RSV_W < 1) begin : g_bad_hi
      $error("instruction word too narrow for opcode and reserved field");
   end

   logic [NSTEP:1] t;
   for (genvar k = 1; k <= NSTEP; k++) begin : g_tline
      assign t[k] = (step == STEP_W'(k));
   end

   logic [3:0]       opc;
   logic [RSV_W-1:0] rsv;
   logic             is_add, is_sub, is_br, is_bad, arith;

   assign opc    = ir_hi[HI_W-1 -: 4];
   assign rsv    = ir_hi[RSV_W-1:0];
   assign is_add = (opc == OPC_ADDI) && (rsv == '0);
   assign is_sub = (opc == OPC_SUBI) && (rsv == '0);
   assign is_br  = (opc == OPC_BRAN) && (rsv == '0);
   assign is_bad = !(is_add || is_sub || is_br);
   assign arith  = is_add || is_sub;

   // sums of products of timing lines and decode lines
   always_comb begin
      c.pc_out  = t[1];
      c.mar_in  = t[1] | (t[4] & arith);
      c.rd_req  = t[1] | (t[4] & arith);
      c.sel4    = t[1];
      c.z_in    = t[1] | (t[6] & arith) | (t[4] & is_br);
      c.z_out   = t[2] | (t[7] & arith) | (t[5] & is_br);
      c.pc_in   = t[2] | (t[5] & is_br);
      c.y_in    = t[2] | (t[5] & arith);
      c.wmfc    = t[2] | (t[5] & arith);
      c.mdr_out = t[3] | (t[6] & arith);
      c.ir_in   = t[3];
      c.rs_out  = t[4] & arith;
      c.rd_out  = t[5] & arith;
      c.rd_in   = t[7] & arith;
      c.off_out = t[4] & is_br;
      c.bad     = t[4] & is_bad;
      c.fin     = (t[7] & arith) | (t[5] & is_br) | (t[4] & is_bad);
      c.alu     = (t[6] & is_sub) ? ALU_SUB : ALU_ADD;
   end
endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
   import sbc_pkg::*;
#(
   parameter int              DATA_W   = 16,
   parameter int              REG_AW   = 4,
   parameter int              OFF_W    = 8,
   parameter int              PC_STEP  = 4,
   parameter logic [DATA_W-1:0] RESET_PC = 16'h0100,
   parameter bit              ZERO_R0  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_t             c,
   input  logic              mem_mfc,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-9:0] ir_hi,
   output logic [DATA_W-1:0] mar_q,
   output logic [DATA_W-1:0] bus
);
   localparam int NREG = 1 << REG_AW;

   if (REG_AW < 1 || REG_AW > 4) begin : g_bad_aw
      $error("REG_AW must be 1 to 4");
   end
   if (OFF_W > 8 || OFF_W >= DATA_W) begin : g_bad_off
      $error("OFF_W must fit the low byte");
   end

   logic [DATA_W-1:0] pc_q, y_q, z_q, mdr_q, ir_q, alu_a, alu_r, off_ext;
   logic [DATA_W-1:0] rf [NREG];
   logic [REG_AW-1:0] rs_idx, rd_idx;

   assign rs_idx  = ir_q[4 +: REG_AW];
   assign rd_idx  = ir_q[REG_AW-1:0];
   assign off_ext = {{(DATA_W-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};
   assign ir_hi   = ir_q[DATA_W-1:8];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (ZERO_R0 && i == 0) begin : g_zero
         assign rf[i] = '0;
      end else begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  rf[i] <= DATA_W'(i);
            else if (c.rd_in && rd_idx == REG_AW'(i))    rf[i] <= bus;
         end
      end
   end

   // shared bus: gated OR of every source
   assign bus = ({DATA_W{c.pc_out}}  & pc_q)
              | ({DATA_W{c.z_out}}   & z_q)
              | ({DATA_W{c.mdr_out}} & mdr_q)
              | ({DATA_W{c.rs_out}}  & rf[rs_idx])
              | ({DATA_W{c.rd_out}}  & rf[rd_idx])
              | ({DATA_W{c.off_out}} & off_ext);

   assign alu_a = c.sel4 ? DATA_W'(PC_STEP) : y_q;

   always_comb begin
      unique case (c.alu)
         ALU_ADD:   alu_r = alu_a + bus;
         ALU_SUB:   alu_r = alu_a - bus;
         ALU_XOR:   alu_r = alu_a ^ bus;
         default:   alu_r = bus;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         y_q   <= '0;
         z_q   <= '0;
         mdr_q <= '0;
         ir_q  <= '0;
         mar_q <= '0;
      end else begin
         if (c.pc_in)  pc_q  <= bus;
         if (c.y_in)   y_q   <= bus;
         if (c.z_in)   z_q   <= alu_r;
         if (mem_mfc)  mdr_q <= mem_rdata;
         if (c.ir_in)  ir_q  <= bus;
         if (c.mar_in) mar_q <= bus;
      end
   end

   p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({c.pc_out, c.z_out, c.mdr_out, c.rs_out, c.rd_out, c.off_out}));

   p_z_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !c.z_in |=> $stable(z_q));

   p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !c.pc_in |=> $stable(pc_q));
endmodule

// File: rtl/sbc_hw_seq.sv
module sbc_hw_seq
   import sbc_pkg::*;
#(
   parameter int                DATA_W   = 16,
   parameter int                REG_AW   = 4,
   parameter int                STEP_W   = 3,
   parameter int                PC_STEP  = 4,
   parameter logic [DATA_W-1:0] RESET_PC = 16'h0100,
   parameter bit                ZERO_R0  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_mfc,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_read,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] bus_mon,
   output logic [STEP_W-1:0] step_mon,
   output logic              instr_end,
   output logic              illegal_op
);
   localparam int HI_W = DATA_W - 8;

   if (DATA_W < 13) begin : g_bad_dw
      $error("DATA_W must be at least 13");
   end

   ctrl_t             c;
   logic [STEP_W-1:0] step;
   logic [HI_W-1:0]   ir_hi;

   sbc_step_ctr #(.STEP_W(STEP_W)) u_step (
      .clk  (clk),
      .rst_n(rst_n),
      .wmfc (c.wmfc),
      .mfc  (mem_mfc),
      .fin  (c.fin),
      .step (step)
   );

   sbc_decode #(.STEP_W(STEP_W), .HI_W(HI_W)) u_dec (
      .step (step),
      .ir_hi(ir_hi),
      .c    (c)
   );

   sbc_datapath #(
      .DATA_W  (DATA_W),
      .REG_AW  (REG_AW),
      .OFF_W   (8),
      .PC_STEP (PC_STEP),
      .RESET_PC(RESET_PC),
      .ZERO_R0 (ZERO_R0)
   ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .c        (c),
      .mem_mfc  (mem_mfc),
      .mem_rdata(mem_rdata),
      .ir_hi    (ir_hi),
      .mar_q    (mem_addr),
      .bus      (bus_mon)
   );

   assign mem_read   = c.rd_req;
   assign step_mon   = step;
   assign instr_end  = c.fin;
   assign illegal_op = c.bad;
endmodule

// File: tb/sbc_hw_seq_test.sv
module sbc_hw_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_mfc = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        mem_read, instr_end, illegal_op;
   logic [15:0] mem_addr, bus_mon;
   logic [2:0]  step_mon;

   always #5 clk = ~clk;

   sbc_hw_seq uut (
      .clk(clk), .rst_n(rst_n), .mem_mfc(mem_mfc), .mem_rdata(mem_rdata),
      .mem_read(mem_read), .mem_addr(mem_addr), .bus_mon(bus_mon),
      .step_mon(step_mon), .instr_end(instr_end), .illegal_op(illegal_op)
   );

   typedef struct {
      logic [15:0] val;
      logic        bad;
      int          cyc;
      string       tag;
   } item_t;
   typedef struct {
      logic [15:0] addr;
      string       tag;
   } aitem_t;

   item_t       exp_q[$];
   aitem_t      addr_q[$];
   logic [15:0] mem [int];
   logic [15:0] regs [16];
   logic [15:0] mpc;
   int          n_chk = 0;
   int          n_fail = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int lat_of(logic [15:0] a);
      return int'((a >> 2) % 3);
   endfunction

   function automatic logic [15:0] rd_mem(logic [15:0] a);
      return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0;
   endfunction

   // driver: place one word, predict its outcome from the requirements
   task automatic put(logic [15:0] w);
      item_t       it;
      logic [15:0] npc, a, d;
      logic [3:0]  rs, rd;
      int          lf;
      mem[int'(mpc)] = w;
      addr_q.push_back('{mpc, "R2 fetch address"});
      lf  = lat_of(mpc);
      npc = mpc + 16'd4;
      rs  = w[7:4];
      rd  = w[3:0];
      if (w[11:8] == 4'h0 && (w[15:12] == 4'h1 || w[15:12] == 4'h2)) begin
         a = regs[rs];
         d = rd_mem(a);
         addr_q.push_back('{a, "R4 operand address"});
         regs[rd] = (w[15:12] == 4'h1) ? regs[rd] + d : regs[rd] - d;
         it = '{regs[rd], 1'b0, 7 + lf + lat_of(a),
                (w[15:12] == 4'h1) ? "R4 add" : "R5 sub"};
      end else if (w[11:8] == 4'h0 && w[15:12] == 4'h3) begin
         npc = npc + {{8{w[7]}}, w[7:0]};
         it  = '{npc, 1'b0, 5 + lf, "R6 branch"};
      end else begin
         it  = '{16'h0, 1'b1, 4 + lf, "R7 illegal"};
      end
      exp_q.push_back(it);
      mpc = npc;
   endtask

   // memory responder: mfc after one cycle plus address-dependent latency
   initial begin
      forever begin
         @(negedge clk); #1;
         if (rst_n && mem_read) begin
            logic [15:0] a;
            @(negedge clk); #1;
            a = mem_addr;
            if (addr_q.size() > 0) begin
               aitem_t ai;
               ai = addr_q.pop_front();
               chk(ai.tag, a, ai.addr);
            end
            repeat (lat_of(a)) begin
               @(negedge clk); #1;
            end
            mem_mfc   = 1'b1;
            mem_rdata = rd_mem(a);
            @(negedge clk); #1;
            mem_mfc   = 1'b0;
         end
      end
   end

   // monitor: pops an expected item at each end pulse
   initial begin
      int   cyc;
      logic was_end;
      cyc = 0;
      was_end = 1'b0;
      wait (rst_n === 1'b1);
      #1;
      forever begin
         cyc++;
         if (was_end) chk("R10 restart", step_mon, 3'd1);
         was_end = 1'b0;
         if (instr_end && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            chk({it.tag, " bus"}, bus_mon, it.val);
            chk({it.tag, " illegal flag"}, illegal_op, it.bad);
            chk({"R3 cycles ", it.tag}, cyc, it.cyc);
            was_end = 1'b1;
         end
         if (instr_end) cyc = 0;
         @(negedge clk); #1;
      end
   end

   initial begin
      int guard;
      for (int i = 0; i < 16; i++) regs[i] = 16'(i);   // R11 reset values
      for (int i = 0; i < 16; i++) mem[i] = 16'h0101 * 16'(i) + 16'h0005;
      mpc = 16'h0100;
      put(16'h1038);   // add (R3),R8
      put(16'h1058);   // add (R5),R8
      put(16'h2029);   // sub (R2),R9
      put(16'h3008);   // branch +8
      put(16'h107A);   // add (R7),R10
      put(16'h7000);   // undefined opcode
      put(16'h30C0);   // branch -64
      put(16'h2008);   // sub (R0),R8
      put(16'h101F);   // add (R1),R15
      put(16'hF123);   // undefined opcode
      put(16'h1069);   // add (R6),R9
      put(16'h3000);   // branch +0
      put(16'h104B);   // add (R4),R11
      put(16'h1138);   // reserved bits set: illegal

      repeat (3) @(negedge clk);
      #1;
      chk("R1 step in reset", step_mon, 3'd1);
      chk("R1 end in reset", instr_end, 1'b0);
      chk("R1 illegal in reset", illegal_op, 1'b0);
      chk("R1 read in reset", mem_read, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;

      guard = 0;
      while ((exp_q.size() > 0 || addr_q.size() > 0) && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      if (guard >= 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog pending=%0d expected=0", exp_q.size());
      end
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule